// File: doc/BRIEF.md
# Dual-Channel Edge-Latched Interrupt Controller

The block gathers six active-low interrupt requests (timer, horizontal border, vertical border, serial data, keyboard, cartridge) and routes them to two CPU interrupt lines. One line is a normal interrupt (`irq_n_o`) and the other is a fast interrupt (`firq_n_o`). Each line has its own channel. A channel holds a per-source enable mask and a set of latched status bits. A source sets its status bit when it falls while enabled. It also sets it when it is enabled while already low.

Software programs the block through a small synchronous register port. Writing a channel register loads that channel's enable mask. Reading the same register returns the latched status and clears all of that channel's status bits in one step. A separate control register holds one master gate for each output line. A source that stays low after it has been serviced stays quiet until software clears its enable bit and sets it again. Because a read discards the status, software must keep the value it read.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, all enables, status bits and master gates are zero, both `irq_n_o` and `firq_n_o` are high, and `data_o` is zero.
- R2: Register map on `addr_i`: 0 is control, 2 is the IRQ channel, 3 is the FIRQ channel. Control bit 5 gates `irq_n_o` and bit 4 gates `firq_n_o`. An output is low exactly when its master bit is set and at least one status bit of its channel is set.
- R3: Status and enable bit positions are 5 timer, 4 horizontal border, 3 vertical border, 2 serial, 1 keyboard, 0 cartridge (`src_n_i` uses the same order). An enabled source that goes from high to low sets its status bit. The output drops three clock edges after the input changes.
- R4: Writing an enable bit from 0 to 1 while its synchronized source is low sets the status bit at that write's clock edge.
- R5: A read of a channel register puts its status on `data_o[5:0]` at the read edge. The same read clears every status bit of that channel, and only of that channel.
- R6: Clearing an enable bit leaves a latched status bit, and the asserted output, unchanged.
- R7: A source held low does not set its status bit again after a read. Writing its enable bit as 1 while it is already 1 does not set it either. Writing the enable bit 0 and then 1 sets it again.
- R8: The two channels latch independently. A source enabled in both channels sets a status bit in each.
- R9: A qualifying edge in the same cycle as a status read is not lost. The read does not return it, and the bit stays latched afterwards.
- R10: Bits 7:6 of every read are zero, and reading address 1 returns zero. A control read returns bits 5 and 4 only.
- R11: A falling edge on a source whose enable bit is 0 sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_n_i | input | 6 | Asynchronous interrupt requests, active low |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | 8 | Write data |
| data_o | output | 8 | Read data, held until the next read |
| irq_n_o | output | 1 | Normal interrupt, active low |
| firq_n_o | output | 1 | Fast interrupt, active low |

## Verification
A change on a source input reaches the status register on the third rising edge after it. The first two edges are the synchronizer stages and the third is the latch. The interrupt outputs are combinational from the status bits, so the bench looks at them on the falling edge after that third rising edge. It also checks that they are still high one falling edge earlier.

An enable write, a read and a control write take effect at the rising edge that samples the strobe. Read data and the interrupt outputs are therefore checked on the next falling edge. In the random phase, a cycle-level model of the same latencies is compared against both outputs and `data_o` on every falling edge. That run covers edges that land together with reads and writes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC        = 6;
  localparam int unsigned DW          = 8;
  localparam int unsigned AW          = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned NCH         = 2;

  localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [AW-1:0] ADDR_IRQ  = 2'd2;
  localparam logic [AW-1:0] ADDR_FIRQ = 2'd3;

  localparam int unsigned CTRL_IRQ_BIT  = 5;
  localparam int unsigned CTRL_FIRQ_BIT = 4;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned N      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_n_i,
  output logic [N-1:0] low_o,
  output logic [N-1:0] fall_o
);
  logic [STAGES-1:0][N-1:0] chain_q;
  logic [N-1:0]             prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= '1;
          else         chain_q[g] <= src_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= '1;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign low_o  = ~chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

  // a single transition yields a one-cycle pulse
  assert_fall_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/irq_channel.sv
module irq_channel #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_low_i,
  input  logic [N-1:0] src_fall_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o,
  output logic         pending_o
);
  logic [N-1:0] en_q, status_q;
  logic [N-1:0] en_rise, set_vec;

  // enabling a source that is already low latches it at the write edge
  assign en_rise = wr_i ? (wdata_i & ~en_q & src_low_i) : '0;
  assign set_vec = (src_fall_i & en_q) | en_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  // a read clears everything; a same-cycle set survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (rd_i ? '0 : status_q) | set_vec;
  end

  assign status_o  = status_q;
  assign pending_o = |status_q;

  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> ((status_q & ~$past(set_vec)) == '0));

  assert_status_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_set_needs_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_q) & ~$past(wr_i ? wdata_i : '0)) == '0));

  assert_held_low_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && src_fall_i == '0) |=> ((status_q & ~$past(status_q)) == '0));
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [5:0]    src_n_i,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    data_o,
  output logic          irq_n_o,
  output logic          firq_n_o
);
  localparam logic [AW-1:0] CH_ADDR [NCH] = '{ADDR_IRQ, ADDR_FIRQ};
  localparam int unsigned   CH_MBIT [NCH] = '{CTRL_IRQ_BIT, CTRL_FIRQ_BIT};

  src_vec_t          src_low, src_fall;
  src_vec_t          ch_status [NCH];
  logic [NCH-1:0]    ch_pending;
  logic [NCH-1:0]    master_q;
  logic [NCH-1:0]    ch_rd;
  logic [DW-1:0]     rdata_d, data_q;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata_i[DW-1:NSRC], wdata_i[3:0]};

  irq_src_sync #(.N(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_n_i (src_n_i),
    .low_o   (src_low),
    .fall_o  (src_fall)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign ch_rd[c] = rd_i && (addr_i == CH_ADDR[c]);
      irq_channel #(.N(NSRC)) u_ch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_low_i  (src_low),
        .src_fall_i (src_fall),
        .wr_i       (wr_i && (addr_i == CH_ADDR[c])),
        .rd_i       (ch_rd[c]),
        .wdata_i    (wdata_i[NSRC-1:0]),
        .status_o   (ch_status[c]),
        .pending_o  (ch_pending[c])
      );
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             master_q[c] <= 1'b0;
        else if (wr_i && addr_i == ADDR_CTRL)    master_q[c] <= wdata_i[CH_MBIT[c]];
      end
    end
  endgenerate

  always_comb begin
    rdata_d = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_d[CTRL_IRQ_BIT]  = master_q[0];
        rdata_d[CTRL_FIRQ_BIT] = master_q[1];
      end
      ADDR_IRQ:  rdata_d[NSRC-1:0] = ch_status[0];
      ADDR_FIRQ: rdata_d[NSRC-1:0] = ch_status[1];
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (rd_i) data_q <= rdata_d;
  end

  assign data_o   = data_q;
  assign irq_n_o  = ~(ch_pending[0] & master_q[0]);
  assign firq_n_o = ~(ch_pending[1] & master_q[1]);

  assert_unused_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o[DW-1:NSRC] == '0);

  assert_gated_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CTRL && !wdata_i[CTRL_IRQ_BIT]) |=> irq_n_o);

  assert_read_channel_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_rd[0] |=> ((ch_status[1] & $past(ch_status[1])) == $past(ch_status[1])));
endmodule

// File: tb/dual_irq_ctrl_bench.sv
module dual_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src_n = 6'h3f;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] data;
  logic       irq_n, firq_n;
  int         n_tests = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  dual_irq_ctrl u_dual_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_n_i(src_n), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wd), .data_o(data),
    .irq_n_o(irq_n), .firq_n_o(firq_n)
  );

  // reference model built from the requirements
  logic [5:0] m_s1, m_s2, m_p;
  logic [5:0] m_en [2];
  logic [5:0] m_st [2];
  logic [1:0] m_ctl;
  logic [7:0] m_rd;

  function automatic logic [7:0] exp_read(input logic [1:0] a, input logic [5:0] s0,
                                          input logic [5:0] s1, input logic [1:0] ctl);
    case (a)
      2'd0: return {2'b00, ctl[0], ctl[1], 4'b0};
      2'd2: return {2'b00, s0};
      2'd3: return {2'b00, s1};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_p <= '1;
      m_en[0] <= '0; m_en[1] <= '0; m_st[0] <= '0; m_st[1] <= '0;
      m_ctl <= '0; m_rd <= '0;
    end else begin
      logic [5:0] fall, rise, set_v;
      fall = m_p & ~m_s2;
      for (int ch = 0; ch < 2; ch++) begin
        logic wsel, rsel;
        wsel = wr && (addr == 2'(2 + ch));
        rsel = rd && (addr == 2'(2 + ch));
        rise = wsel ? (wd[5:0] & ~m_en[ch] & ~m_s2) : 6'h0;
        set_v = (fall & m_en[ch]) | rise;
        m_st[ch] <= (rsel ? 6'h0 : m_st[ch]) | set_v;
        if (wsel) m_en[ch] <= wd[5:0];
      end
      if (wr && addr == 2'd0) m_ctl <= {wd[4], wd[5]};
      if (rd) m_rd <= exp_read(addr, m_st[0], m_st[1], m_ctl);
      m_s1 <= src_n; m_s2 <= m_s1; m_p <= m_s2;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wd = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = data;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("[TB] FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({6'b0, irq_n, firq_n}, 8'h03, "R1 outputs");
    check(data, 8'h00, "R1 data");
    do_read(2'd2, r); check(r, 8'h00, "R1 irq status");
    do_read(2'd0, r); check(r, 8'h00, "R1 ctrl");

    // R3 timer edge, latency 3 edges; R2 gating
    do_write(2'd0, 8'h30);
    do_write(2'd2, 8'h20);
    src_n[5] = 1'b0;
    repeat (2) @(negedge clk);
    check({7'b0, irq_n}, 8'h01, "R3 not before third edge");
    @(negedge clk);
    check({7'b0, irq_n}, 8'h00, "R3 irq asserted");
    check({7'b0, firq_n}, 8'h01, "R8 firq untouched");
    // R6 clearing enable keeps status
    do_write(2'd2, 8'h00);
    check({7'b0, irq_n}, 8'h00, "R6 irq still low");
    // R2 master off hides it, on shows it
    do_write(2'd0, 8'h10);
    check({7'b0, irq_n}, 8'h01, "R2 masked");
    do_write(2'd0, 8'h30);
    check({7'b0, irq_n}, 8'h00, "R2 unmasked");
    // R5 read returns and clears
    do_read(2'd2, r); check(r, 8'h20, "R5 status value");
    check({7'b0, irq_n}, 8'h01, "R5 irq released");
    src_n[5] = 1'b1;
    // R11 edge on disabled source
    src_n[1] = 1'b0; repeat (5) @(negedge clk);
    check({7'b0, irq_n}, 8'h01, "R11 disabled edge");
    do_read(2'd2, r); check(r, 8'h00, "R11 status empty");
    // R4 enable while low
    do_write(2'd2, 8'h02);
    check({7'b0, irq_n}, 8'h00, "R4 immediate latch");
    do_read(2'd2, r); check(r, 8'h02, "R4 keyboard bit");
    // R7 held low, no relatch; rewriting 1 no relatch; 0 then 1 relatches
    repeat (6) @(negedge clk);
    check({7'b0, irq_n}, 8'h01, "R7 no relatch");
    do_write(2'd2, 8'h02);
    check({7'b0, irq_n}, 8'h01, "R7 rewrite one");
    do_write(2'd2, 8'h00);
    do_write(2'd2, 8'h02);
    check({7'b0, irq_n}, 8'h00, "R7 reenable relatch");
    do_read(2'd2, r); check(r, 8'h02, "R7 status");
    src_n[1] = 1'b1; do_write(2'd2, 8'h00);
    // R8 both channels
    do_write(2'd2, 8'h01); do_write(2'd3, 8'h01);
    repeat (2) @(negedge clk);
    src_n[0] = 1'b0; repeat (3) @(negedge clk);
    check({6'b0, irq_n, firq_n}, 8'h00, "R8 both asserted");
    do_read(2'd3, r); check(r, 8'h01, "R8 firq status");
    check({6'b0, irq_n, firq_n}, 8'h01, "R8 irq kept");
    do_read(2'd2, r); check(r, 8'h01, "R8 irq status");
    src_n[0] = 1'b1;
    // R9 edge coincident with read (serial bit 2)
    do_write(2'd2, 8'h04);
    repeat (2) @(negedge clk);
    src_n[2] = 1'b0;
    repeat (2) @(negedge clk);
    do_read(2'd2, r); check(r, 8'h00, "R9 read misses new edge");
    check({7'b0, irq_n}, 8'h00, "R9 edge kept");
    do_read(2'd2, r); check(r, 8'h04, "R9 bit latched");
    src_n[2] = 1'b1;
    // R10 unused bits and address 1
    do_write(2'd0, 8'hff);
    do_read(2'd0, r); check(r, 8'h30, "R10 ctrl readback");
    do_read(2'd1, r); check(r, 8'h00, "R10 addr1");
    do_write(2'd2, 8'hff);
    do_read(2'd2, r); check(r & 8'hc0, 8'h00, "R10 high bits");

    // constrained random phase against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      check({6'b0, irq_n, firq_n}, {6'b0, ~(|m_st[0] & m_ctl[0]), ~(|m_st[1] & m_ctl[1])},
            "R2 R3 R9 random outputs");
      check(data, m_rd, "R5 R10 random read");
      if ($urandom_range(7) == 0) src_n[$urandom_range(5)] ^= 1'b1;
      op = $urandom_range(9);
      addr = 2'($urandom_range(3));
      wd = 8'($urandom);
      wr = (op == 0) || (op == 1 && addr == 2'd0);
      rd = (op == 2) || (op == 3);
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
    end

    done = 1'b1;
    finish_run();
  end
endmodule